// File: doc/BRIEF.md
# Integer Execute Unit with Multiply/Divide Result Pair

This block is the 32-bit integer execute stage of a simple load/store processor core. A 5-bit operation code selects one of 24 functions applied to two operands and a separate shift-amount field. It produces a data result and a one-bit branch condition in the same cycle, so a decoder upstream can use the condition to steer the program counter.

Two result registers, `hi_q` and `lo_q`, receive multiply and divide results at the clock edge. The same registers can also be loaded directly from operand A. Each has its own write enable, and both are always visible on the outputs, so the move-from operations need no extra op code.

Load-upper-immediate needs no op of its own: it is a fixed left shift with a shift amount of 16. Load and store addresses are computed with the add op.

Top module: `alu32_hilo`

## Requirements
- R1: Op 0 gives A+B, op 1 gives A-B, op 4 gives A&B, op 5 gives A|B and op 6 gives A^B, all modulo 2^32. The condition output is low for these ops.
- R2: The fixed shifts shift B by the `shamt` input. Op 7 is a logical left shift, op 9 is a logical right shift and op 11 is an arithmetic right shift. Op 7 with `shamt`=16 places B[15:0] in the upper half with zeros below.
- R3: The variable shifts shift B by A[4:0]. Op 8 is a logical left shift, op 10 is a logical right shift and op 12 is an arithmetic right shift.
- R4: Ops 13 to 18 compare A and B as signed numbers. The condition output is high when A==B for op 13, A<B for op 14, A<=B for op 15, A>B for op 16, A>=B for op 17 and A!=B for op 18. The result is zero for these ops. Every op outside 13 to 18 holds the condition output low.
- R5: Op 20 returns 1 when A<B as signed numbers and 0 otherwise. Op 21 does the same with an unsigned compare.
- R6: Op 19 returns A as the result. At the next clock edge it writes A into HI when `hi_we` is high and into LO when `lo_we` is high.
- R7: Op 2 (signed) and op 22 (unsigned) form the 64-bit product of A and B. At the clock edge the upper half goes to HI when `hi_we` is high, and the lower half goes to LO when `lo_we` is high. The result output is zero.
- R8: Op 3 (signed) and op 23 (unsigned) divide A by B. At the clock edge the quotient goes to LO (gated by `lo_we`) and the remainder goes to HI (gated by `hi_we`). The result output is zero. Signed division truncates toward zero, and the remainder takes the sign of A. Dividing 0x80000000 by -1 gives quotient 0x80000000 and remainder 0.
- R9: A divide op with B==0 leaves HI and LO unchanged, whatever the enables.
- R10: Ops 24 to 31 give a zero result with the condition output low. No op other than 2, 3, 19, 22 and 23 changes HI or LO.
- R11: Reset (active low, asynchronous) clears HI and LO to zero. With both enables low, HI and LO hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 5 | Operation code |
| a | input | 32 | Operand A |
| b | input | 32 | Operand B |
| shamt | input | 5 | Shift amount for fixed shifts |
| hi_we | input | 1 | HI write enable |
| lo_we | input | 1 | LO write enable |
| result | output | 32 | Data result |
| cond | output | 1 | Branch condition |
| hi_q | output | 32 | HI register |
| lo_q | output | 32 | LO register |

## Verification
The properties check four things on every cycle: the condition output is confined to the compare ops, the unused ops give a zero result, HI and LO hold whenever they are not enabled or the divisor is zero, and op 19 delivers A into whichever register is enabled. Several behaviours can only be shown by the bench's scenarios against its own model. These are the arithmetic values themselves, the sign rules of division including the overflow quotient, the signed/unsigned split in the compares, and the treatment of load-upper as a shift by 16.

// File: rtl/alu32_hilo.sv
module alu32_hilo #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    op,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [SW-1:0] shamt,
  input  logic          hi_we,
  input  logic          lo_we,
  output logic [W-1:0]  result,
  output logic          cond,
  output logic [W-1:0]  hi_q,
  output logic [W-1:0]  lo_q
);
  localparam logic [4:0] OP_ADD = 5'd0,  OP_SUB = 5'd1,  OP_MUL = 5'd2,  OP_DIV = 5'd3;
  localparam logic [4:0] OP_AND = 5'd4,  OP_OR  = 5'd5,  OP_XOR = 5'd6;
  localparam logic [4:0] OP_SLL = 5'd7,  OP_SLLV = 5'd8, OP_SRL = 5'd9, OP_SRLV = 5'd10;
  localparam logic [4:0] OP_SRA = 5'd11, OP_SRAV = 5'd12;
  localparam logic [4:0] OP_EQ = 5'd13, OP_LT = 5'd14, OP_LE = 5'd15;
  localparam logic [4:0] OP_GT = 5'd16, OP_GE = 5'd17, OP_NE = 5'd18;
  localparam logic [4:0] OP_PASS = 5'd19, OP_SLT = 5'd20, OP_SLTU = 5'd21;
  localparam logic [4:0] OP_MULU = 5'd22, OP_DIVU = 5'd23;

  logic signed [W-1:0] sa, sb;
  logic [SW-1:0]       vsh;
  assign sa  = $signed(a);
  assign sb  = $signed(b);
  assign vsh = a[SW-1:0];

  always_comb begin
    result = '0;
    cond   = 1'b0;
    case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_SLL:  result = b << shamt;
      OP_SRL:  result = b >> shamt;
      OP_SRA:  result = W'(sb >>> shamt);
      OP_SLLV: result = b << vsh;
      OP_SRLV: result = b >> vsh;
      OP_SRAV: result = W'(sb >>> vsh);
      OP_EQ:   cond = (a == b);
      OP_LT:   cond = (sa <  sb);
      OP_LE:   cond = (sa <= sb);
      OP_GT:   cond = (sa >  sb);
      OP_GE:   cond = (sa >= sb);
      OP_NE:   cond = (a != b);
      OP_PASS: result = a;
      OP_SLT:  result = W'(sa < sb);
      OP_SLTU: result = W'(a < b);
      default: result = '0;
    endcase
  end

  logic [2*W-1:0] prod_s, prod_u;
  assign prod_s = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
  assign prod_u = {{W{1'b0}}, a} * {{W{1'b0}}, b};

  logic          b_zero;
  logic [W-1:0]  divisor, mag_a, mag_b, uq_s, ur_s, q_s, r_s, q_u, r_u;
  assign b_zero  = (b == '0);
  assign divisor = b_zero ? W'(1) : b;
  assign mag_a   = a[W-1] ? -a : a;
  assign mag_b   = divisor[W-1] ? -divisor : divisor;
  assign uq_s    = mag_a / mag_b;
  assign ur_s    = mag_a % mag_b;
  assign q_s     = (a[W-1] ^ divisor[W-1]) ? -uq_s : uq_s;
  assign r_s     = a[W-1] ? -ur_s : ur_s;
  assign q_u     = a / divisor;
  assign r_u     = a % divisor;

  logic          hl_wr;
  logic [W-1:0]  hi_nx, lo_nx;
  always_comb begin
    hl_wr = 1'b1;
    hi_nx = hi_q;
    lo_nx = lo_q;
    case (op)
      OP_MUL:  {hi_nx, lo_nx} = prod_s;
      OP_MULU: {hi_nx, lo_nx} = prod_u;
      OP_DIV:  begin hl_wr = !b_zero; hi_nx = r_s; lo_nx = q_s; end
      OP_DIVU: begin hl_wr = !b_zero; hi_nx = r_u; lo_nx = q_u; end
      OP_PASS: begin hi_nx = a; lo_nx = a; end
      default: hl_wr = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (hl_wr && hi_we) hi_q <= hi_nx;
      if (hl_wr && lo_we) lo_q <= lo_nx;
    end
  end
endmodule

// File: rtl/alu32_hilo_chk.sv
module alu32_hilo_chk #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    op,
  input logic [W-1:0]  a,
  input logic [W-1:0]  b,
  input logic [SW-1:0] shamt,
  input logic          hi_we,
  input logic          lo_we,
  input logic [W-1:0]  result,
  input logic          cond,
  input logic [W-1:0]  hi_q,
  input logic [W-1:0]  lo_q
);
  assert_cond_only_compare_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op < 5'd13 || op > 5'd18) |-> !cond);

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 5'd24) |-> (result == '0 && !cond));

  assert_slt_bool_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd20 || op == 5'd21) |-> (result <= W'(1)));

  assert_divzero_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 5'd3 || op == 5'd23) && b == '0) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_we && !lo_we) |=> ($stable(hi_q) && $stable(lo_q)));

  assert_other_ops_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op == 5'd2 || op == 5'd3 || op == 5'd19 || op == 5'd22 || op == 5'd23)
      |=> ($stable(hi_q) && $stable(lo_q)));

  assert_pass_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd19 && hi_we) |=> (hi_q == $past(a)));

  assert_pass_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 5'd19 && lo_we) |=> (lo_q == $past(a)));
endmodule

bind alu32_hilo alu32_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .shamt(shamt),
  .hi_we(hi_we), .lo_we(lo_we), .result(result), .cond(cond),
  .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/alu32_hilo_test.sv
module alu32_hilo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] a = '0, b = '0;
  logic [4:0]  shamt = '0;
  logic        hi_we = 1'b0, lo_we = 1'b0;
  logic [31:0] result, hi_q, lo_q;
  logic        cond;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_hi = '0, m_lo = '0;

  always #2 clk = ~clk;

  alu32_hilo uut (.clk(clk), .rst_n(rst_n), .op(op), .a(a), .b(b), .shamt(shamt),
    .hi_we(hi_we), .lo_we(lo_we), .result(result), .cond(cond), .hi_q(hi_q), .lo_q(lo_q));

  function automatic string tag_of(input logic [4:0] o);
    if (o inside {0, 1, 4, 5, 6}) return "R1";
    if (o inside {7, 9, 11}) return "R2";
    if (o inside {8, 10, 12}) return "R3";
    if (o inside {[13:18]}) return "R4";
    if (o inside {20, 21}) return "R5";
    if (o == 19) return "R6";
    if (o inside {2, 22}) return "R7";
    if (o inside {3, 23}) return "R8";
    return "R10";
  endfunction

  function automatic logic [31:0] exp_res(input logic [4:0] o, input logic [31:0] x, y, input logic [4:0] s);
    case (o)
      0: return x + y;
      1: return x - y;
      4: return x & y;
      5: return x | y;
      6: return x ^ y;
      7: return y << s;
      9: return y >> s;
      11: return $signed(y) >>> s;
      8: return y << x[4:0];
      10: return y >> x[4:0];
      12: return $signed(y) >>> x[4:0];
      19: return x;
      20: return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      21: return (x < y) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_cond(input logic [4:0] o, input logic [31:0] x, y);
    case (o)
      13: return x == y;
      14: return $signed(x) <  $signed(y);
      15: return $signed(x) <= $signed(y);
      16: return $signed(x) >  $signed(y);
      17: return $signed(x) >= $signed(y);
      18: return x != y;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_hilo(input logic [4:0] o, input logic [31:0] x, y, input logic hw, lw);
    logic [63:0] p;
    logic [31:0] q, r;
    logic wr;
    wr = 1'b1;
    p = 64'd0;
    case (o)
      2: p = 64'(longint'($signed(x)) * longint'($signed(y)));
      22: p = {32'd0, x} * {32'd0, y};
      3: begin
        if (y == 0) wr = 1'b0;
        else if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) begin q = x; r = 0; p = {r, q}; end
        else begin q = $signed(x) / $signed(y); r = $signed(x) % $signed(y); p = {r, q}; end
      end
      23: begin
        if (y == 0) wr = 1'b0;
        else p = {x % y, x / y};
      end
      19: p = {x, x};
      default: wr = 1'b0;
    endcase
    if (wr && hw) m_hi = p[63:32];
    if (wr && lw) m_lo = p[31:0];
  endtask

  task automatic apply(input logic [4:0] o, input logic [31:0] x, y, input logic [4:0] s,
                       input logic hw, lw, input string tag);
    @(negedge clk);
    op = o; a = x; b = y; shamt = s; hi_we = hw; lo_we = lw;
    #1;
    check(tag, "result", {32'd0, result}, {32'd0, exp_res(o, x, y, s)});
    check(tag, "cond", {63'd0, cond}, {63'd0, exp_cond(o, x, y)});
    model_hilo(o, x, y, hw, lw);
    @(negedge clk);
    hi_we = 1'b0; lo_we = 1'b0;
    check(tag, "hi/lo", {hi_q, lo_q}, {m_hi, m_lo});
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    #1;
    check("R11", "reset hi/lo", {hi_q, lo_q}, 64'd0);
    rst_n = 1'b1;

    apply(5'd0, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R1");
    apply(5'd1, 32'd0, 32'd1, 0, 0, 0, "R1");
    apply(5'd7, 32'd0, 32'h0000_ABCD, 5'd16, 0, 0, "R2");
    apply(5'd11, 32'd0, 32'h8000_0010, 5'd4, 0, 0, "R2");
    apply(5'd9, 32'd0, 32'h8000_0010, 5'd4, 0, 0, "R2");
    apply(5'd10, 32'd37, 32'hF000_0000, 5'd0, 0, 0, "R3");
    apply(5'd12, 32'hFFFF_FFFF, 32'h8000_0000, 5'd0, 0, 0, "R3");
    apply(5'd14, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R4");
    apply(5'd16, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R4");
    apply(5'd15, 32'd5, 32'd5, 0, 0, 0, "R4");
    apply(5'd20, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R5");
    apply(5'd21, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, "R5");
    apply(5'd19, 32'h1234_5678, 32'd0, 0, 1, 0, "R6");
    apply(5'd19, 32'h9ABC_DEF0, 32'd0, 0, 0, 1, "R6");
    apply(5'd2, 32'hFFFF_FFFE, 32'd3, 0, 1, 1, "R7");
    apply(5'd22, 32'hFFFF_FFFE, 32'd3, 0, 1, 1, "R7");
    apply(5'd3, 32'hFFFF_FFF9, 32'd2, 0, 1, 1, "R8");
    apply(5'd3, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1, 1, "R8");
    apply(5'd23, 32'hFFFF_FFF9, 32'd2, 0, 1, 1, "R8");
    apply(5'd3, 32'd77, 32'd0, 0, 1, 1, "R9");
    apply(5'd23, 32'd77, 32'd0, 0, 1, 1, "R9");
    apply(5'd27, 32'hDEAD_BEEF, 32'd5, 5'd3, 1, 1, "R10");
    apply(5'd0, 32'hDEAD_BEEF, 32'd5, 5'd3, 1, 1, "R10");
    apply(5'd2, 32'd9, 32'd9, 0, 0, 0, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [4:0] o;
      logic [31:0] x, y;
      o = 5'($urandom_range(0, 31));
      x = $urandom;
      y = ($urandom_range(0, 7) == 0) ? 32'd0 : $urandom;
      if ($urandom_range(0, 3) == 0) y = x;
      apply(o, x, y, 5'($urandom), 1'($urandom), 1'($urandom), tag_of(o));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule